// File: doc/BRIEF.md
# Per-Lane Instruction Line Buffer with Replay

This block stores a fixed number of instruction-fetch lines, each split into byte lanes, and delivers them to a length-decoding consumer. Every byte lane is a FIFO of its own, so each lane's consumer takes the next byte as soon as it has finished with the current one. It does not wait for the other lanes of the same line. Each stored lane word carries one instruction byte and three pre-computed flags: used, first byte of a predicted-taken branch, and branch target. The block stores and returns these flags unchanged. It never interprets them.

The buffer is filled serially through one shift-in port, one lane word per accepted cycle. Delivery starts only when every entry holds data. A mode input then picks one of three behaviours. In drain, each delivered entry is removed. In recirculate, each delivered entry is written back to the tail of its lane, so a finite load becomes an endless repeating stream. In freeze, every lane keeps presenting its head entry and never removes it. The mode may change only while no lane handshake is in progress. After a full drain the block returns to the loading state.

Top module: `line_lane_buffer`

## Requirements
- R1: After reset, `load_ready_o` is 1 and every bit of `lane_valid_o` is 0.
- R2: The n-th accepted load word (n counting from 0) is stored in lane n mod 16 as line n/16. No lane is valid until all 512 words are accepted. In the cycle after the 512th acceptance, all 16 lanes are valid and `load_ready_o` is 0.
- R3: A lane word is 11 bits: [7:0] instruction byte, [8] used flag, [9] taken-branch first-byte flag, [10] branch-target flag. Lane k presents its word on `lane_word_o[11*k +: 11]` exactly as it was loaded.
- R4: A handshake (valid and ready both high at a clock edge) on one lane changes the presented word of that lane only.
- R5: In drain mode (`mode_i` = 0, and also for the value 3), each handshake replaces the lane's word with its next stored line. The lane's valid drops in the cycle after its last entry is taken.
- R6: In recirculate mode (`mode_i` = 1), each handshake appends the delivered word to the tail of its lane. A full lane stays valid, and after 32 handshakes it presents its original head again.
- R7: In freeze mode (`mode_i` = 2), handshakes leave the presented word, the valid and the stored contents of every lane unchanged.
- R8: While lanes are being delivered, load words are ignored and change no lane's contents.
- R9: Once every lane is empty, `load_ready_o` returns to 1 on the next clock edge, and a fresh 512-word load can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 drain, 1 recirculate, 2 freeze, 3 drain |
| load_valid_i | input | 1 | Shift-in word valid |
| load_word_i | input | 11 | Shift-in lane word |
| load_ready_o | output | 1 | Buffer is accepting shift-in words |
| lane_ready_i | input | 16 | Per-lane consumer ready |
| lane_valid_o | output | 16 | Per-lane word valid |
| lane_word_o | output | 176 | Per-lane presented words, lane k at [11k+10:11k] |

## Verification
A load acceptance or a lane handshake takes effect at the clock edge where it happens. The new head word, the valid and `load_ready_o` can be seen right after that edge. The one exception is the return of `load_ready_o` after the last entry is drained, which comes one edge later. The bench drives inputs on the falling edge and samples on the next falling edge after the edge that counts, and it waits one extra cycle before looking at the reload handshake. The expected words come from a pattern function of line, lane and seed. The bench also keeps its own count of pops for each lane.

// File: rtl/llb_pkg.sv
package llb_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 3;
  localparam int WORD_W = DATA_W + FLAG_W;

  // Bit positions of the sideband flags within a lane word
  localparam int USED_BIT   = DATA_W;
  localparam int BRSTART_BIT = DATA_W + 1;
  localparam int TARGET_BIT = DATA_W + 2;

  typedef enum logic [1:0] {
    MODE_DRAIN  = 2'd0,
    MODE_RECIRC = 2'd1,
    MODE_FREEZE = 2'd2,
    MODE_ALT    = 2'd3
  } mode_e;
endpackage

// File: rtl/llb_fill_seq.sv
module llb_fill_seq #(
  parameter int LANES = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_valid_i,
  input  logic                     all_empty_i,
  output logic                     load_ready_o,
  output logic                     deliver_o,
  output logic                     fill_we_o,
  output logic [$clog2(LANES)-1:0] lane_sel_o
);
  localparam int TOTAL  = LANES * DEPTH;
  localparam int CNT_W  = $clog2(TOTAL);
  localparam int LANE_W = $clog2(LANES);

  logic [CNT_W-1:0]  word_cnt_q;
  logic [LANE_W-1:0] lane_q;
  logic              deliver_q;
  logic              accept;
  logic              last_word;

  assign accept    = load_valid_i && !deliver_q;
  assign last_word = (word_cnt_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_cnt_q <= '0;
      lane_q     <= '0;
      deliver_q  <= 1'b0;
    end else if (accept) begin
      word_cnt_q <= last_word ? '0 : word_cnt_q + 1'b1;
      lane_q     <= (lane_q == LANE_W'(LANES - 1)) ? '0 : lane_q + 1'b1;
      if (last_word) deliver_q <= 1'b1;
    end else if (deliver_q && all_empty_i) begin
      deliver_q <= 1'b0;
    end
  end

  assign load_ready_o = !deliver_q;
  assign deliver_o    = deliver_q;
  assign fill_we_o    = accept;
  assign lane_sel_o   = lane_q;
endmodule

// File: rtl/llb_lane_fifo.sv
module llb_lane_fifo
  import llb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              deliver_i,
  input  logic [1:0]        mode_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q, rd_nxt, wr_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop, do_fill, do_recirc, do_drain;

  assign rd_nxt = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
  assign wr_nxt = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;

  assign empty_o   = (cnt_q == '0);
  assign valid_o   = deliver_i && !empty_o;
  assign pop       = valid_o && ready_i;
  assign do_fill   = fill_we_i && !deliver_i && (cnt_q != CNT_W'(DEPTH));
  assign do_recirc = pop && (mode_i == MODE_RECIRC);
  assign do_drain  = pop && (mode_i != MODE_RECIRC) && (mode_i != MODE_FREEZE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (do_fill) begin
      wr_q  <= wr_nxt;
      cnt_q <= cnt_q + 1'b1;
    end else if (do_recirc) begin
      rd_q <= rd_nxt;
      wr_q <= wr_nxt;
    end else if (do_drain) begin
      rd_q  <= rd_nxt;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_fill)        mem_q[wr_q] <= fill_word_i;
    else if (do_recirc) mem_q[wr_q] <= mem_q[rd_q];
  end

  assign word_o = mem_q[rd_q];
endmodule

// File: rtl/line_lane_buffer.sv
module line_lane_buffer
  import llb_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DEPTH = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                mode_i,
  input  logic                      load_valid_i,
  input  logic [WORD_W-1:0]         load_word_i,
  output logic                      load_ready_o,
  input  logic [LANES-1:0]          lane_ready_i,
  output logic [LANES-1:0]          lane_valid_o,
  output logic [LANES*WORD_W-1:0]   lane_word_o
);
  localparam int LANE_W = $clog2(LANES);

  logic              deliver;
  logic              fill_we;
  logic [LANE_W-1:0] lane_sel;
  logic [LANES-1:0]  lane_empty;

  llb_fill_seq #(.LANES(LANES), .DEPTH(DEPTH)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_valid_i (load_valid_i),
    .all_empty_i  (&lane_empty),
    .load_ready_o (load_ready_o),
    .deliver_o    (deliver),
    .fill_we_o    (fill_we),
    .lane_sel_o   (lane_sel)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    llb_lane_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_we_i   (fill_we && (lane_sel == LANE_W'(k))),
      .fill_word_i (load_word_i),
      .deliver_i   (deliver),
      .mode_i      (mode_i),
      .ready_i     (lane_ready_i[k]),
      .valid_o     (lane_valid_o[k]),
      .word_o      (lane_word_o[k*WORD_W +: WORD_W]),
      .empty_o     (lane_empty[k])
    );
  end
endmodule

// File: rtl/line_lane_buffer_chk.sv
module line_lane_buffer_chk #(
  parameter int LANES  = 16,
  parameter int WORD_W = 11
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [1:0]              mode_i,
  input logic                    load_ready_o,
  input logic [LANES-1:0]        lane_valid_o,
  input logic [LANES*WORD_W-1:0] lane_word_o
);
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ready_o |-> (lane_valid_o == '0)); // R2

  AST_FULL_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_ready_o) |-> (&lane_valid_o)); // R2

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ready_o && $past(!load_ready_o) && mode_i == 2'd2 && $past(mode_i) == 2'd2)
    |-> ($stable(lane_word_o) && $stable(lane_valid_o))); // R7

  AST_RELOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_ready_o) |-> ($past(lane_valid_o) == '0)); // R9

  for (genvar k = 0; k < LANES; k++) begin : g_rc
    AST_RECIRC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_ready_o && $past(!load_ready_o) && mode_i == 2'd1 && $past(mode_i) == 2'd1
       && $past(lane_valid_o[k])) |-> lane_valid_o[k]); // R6
  end
endmodule

bind line_lane_buffer line_lane_buffer_chk #(.LANES(LANES), .WORD_W(llb_pkg::WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .load_ready_o (load_ready_o),
  .lane_valid_o (lane_valid_o),
  .lane_word_o  (lane_word_o)
);

// File: tb/line_lane_buffer_tb_top.sv
`timescale 1ns/1ps
module line_lane_buffer_tb_top;
  localparam int LANES = 16;
  localparam int DEPTH = 32;
  localparam int W     = 11;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          mode = 2'd0;
  logic                load_valid = 1'b0;
  logic [W-1:0]        load_word = '0;
  logic                load_ready;
  logic [LANES-1:0]    lane_ready = '0;
  logic [LANES-1:0]    lane_valid;
  logic [LANES*W-1:0]  lane_word;

  int checks = 0;
  int errors = 0;
  int popped [LANES];
  int remain [LANES];

  // Drive table: lane to pop and number of pops, drain mode
  localparam int NSTEP = 8;
  localparam int STEP_LANE [NSTEP] = '{3, 0, 15, 3, 9, 15, 0, 12};
  localparam int STEP_POPS [NSTEP] = '{2, 1, 5, 1, 3, 2, 4, 1};

  always #2.5 clk = ~clk;

  line_lane_buffer #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .load_valid_i (load_valid),
    .load_word_i  (load_word),
    .load_ready_o (load_ready),
    .lane_ready_i (lane_ready),
    .lane_valid_o (lane_valid),
    .lane_word_o  (lane_word)
  );

  function automatic logic [W-1:0] pat(int line, int lane, int seed);
    logic [7:0] d;
    logic [2:0] f;
    d = 8'((line * 5 + lane * 17 + seed) & 255);
    f = 3'((line + lane + seed) % 8);
    return {f, d};
  endfunction

  function automatic logic [W-1:0] lw(int k);
    return lane_word[k*W +: W];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] w);
    @(negedge clk);
    load_valid = 1'b1;
    load_word  = w;
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic pop(int k);
    @(negedge clk);
    lane_ready[k] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lane_ready[k] = 1'b0;
  endtask

  task automatic fill(int seed, bit check_mid);
    for (int n = 0; n < LANES * DEPTH; n++) begin
      push(pat(n / LANES, n % LANES, seed));
      if (check_mid && n == LANES * DEPTH - 2)
        chk(lane_valid == '0 && load_ready, "R2 no valid before full", 32'(lane_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < LANES; k++) begin
      popped[k] = 0;
      remain[k] = DEPTH;
    end
    repeat (3) @(negedge clk);
    chk(load_ready == 1'b1, "R1 load_ready after reset", 32'(load_ready), 1);
    chk(lane_valid == '0, "R1 valid after reset", 32'(lane_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(0, 1'b1);
    chk(&lane_valid, "R2 all valid when full", 32'(lane_valid), 32'hffff);
    chk(load_ready == 1'b0, "R2 load closed", 32'(load_ready), 0);
    for (int k = 0; k < LANES; k++)
      chk(lw(k) == pat(0, k, 0), "R3 head word layout", 32'(lw(k)), 32'(pat(0, k, 0)));

    // R8: load attempts during delivery are ignored
    for (int i = 0; i < 3; i++) push(11'h7ff);
    chk(lw(0) == pat(0, 0, 0), "R8 load ignored", 32'(lw(0)), 32'(pat(0, 0, 0)));

    // Table walk in drain mode
    for (int s = 0; s < NSTEP; s++) begin
      for (int p = 0; p < STEP_POPS[s]; p++) begin
        int l, nb;
        l = STEP_LANE[s];
        nb = (l + 1) % LANES;
        pop(l);
        popped[l]++;
        remain[l]--;
        chk(lw(l) == pat(popped[l], l, 0), "R5 drain next line",
            32'(lw(l)), 32'(pat(popped[l], l, 0)));
        chk(lw(nb) == pat(popped[nb], nb, 0), "R4 neighbour untouched",
            32'(lw(nb)), 32'(pat(popped[nb], nb, 0)));
      end
    end

    // Freeze: lane 5 keeps its head
    mode = 2'd2;
    for (int i = 0; i < 4; i++) begin
      pop(5);
      chk(lw(5) == pat(0, 5, 0) && lane_valid[5], "R7 freeze holds head",
          32'(lw(5)), 32'(pat(0, 5, 0)));
    end

    // Recirculate: lane 7 wraps after DEPTH pops
    mode = 2'd1;
    for (int i = 1; i <= DEPTH + 8; i++) begin
      pop(7);
      chk(lw(7) == pat(i % DEPTH, 7, 0) && lane_valid[7], "R6 recirculate order",
          32'(lw(7)), 32'(pat(i % DEPTH, 7, 0)));
    end
    chk(lw(7) == pat(8, 7, 0), "R6 recirculate wrap", 32'(lw(7)), 32'(pat(8, 7, 0)));

    // Drain everything; mode 3 behaves as drain
    mode = 2'd3;
    for (int k = 0; k < LANES; k++) begin
      int n;
      n = 0;
      while (lane_valid[k] && n < 2 * DEPTH) begin
        pop(k);
        n++;
      end
      chk(n == remain[k], "R5 entries left in lane", 32'(n), 32'(remain[k]));
      chk(lane_valid[k] == 1'b0, "R5 valid drops on empty", 32'(lane_valid[k]), 0);
      if (k < LANES - 1)
        chk(load_ready == 1'b0, "R9 not ready while lanes hold data", 32'(load_ready), 0);
    end
    @(negedge clk);
    chk(load_ready == 1'b1, "R9 ready after full drain", 32'(load_ready), 1);

    // Reload with a new pattern
    mode = 2'd0;
    fill(99, 1'b0);
    chk(&lane_valid, "R9 reload all valid", 32'(lane_valid), 32'hffff);
    chk(lw(0) == pat(0, 0, 99), "R9 reload lane 0", 32'(lw(0)), 32'(pat(0, 0, 99)));
    chk(lw(15) == pat(0, 15, 99), "R9 reload lane 15", 32'(lw(15)), 32'(pat(0, 15, 99)));
    pop(15);
    chk(lw(15) == pat(1, 15, 99), "R3 second line word", 32'(lw(15)), 32'(pat(1, 15, 99)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule